// File: doc/BRIEF.md
# Channel Soft-Value to Stochastic Bit-Stream Encoder

This block converts one received channel sample into a serial stochastic bit stream for a bit-serial iterative decoder. A strobe captures a signed soft sample. The block scales the sample by a fixed fixed-point factor that depends only on the largest expected symbol magnitude and a tuning constant, so no noise estimate is needed. It saturates the scaled log-likelihood ratio to a small signed index and maps that index through a lookup ramp to an 8-bit probability word.

While the run enable is high, the block compares the probability word with a pseudo-random word on every clock and emits one registered stream bit. The bit is 1 only when the probability is strictly greater than the random word. The random words come from a small constant table that is built at elaboration. A pointer walks the table one entry per run cycle and wraps at the end. Each load restarts the pointer at a per-instance seed, so neighbouring encoders produce different streams. The random word used in each cycle is also driven out, so other consumers can share the same source.

Top module: `chan_stoch_enc`

## Requirements
- R1: The scaled value is s = floor(y·SCALE_NUM / 2^SCALE_SH), with defaults 3 and 1. y is the signed two's-complement value of sample_i. s is saturated to the range −32..31 (IDX_W = 6).
- R2: One cycle after a clock edge on which load_i is high, prob_o equals (s + 32)·4. This ranges from 0 to 252 with 8-bit words, and prob_o holds that value until the next load.
- R3: The random table has 16 entries. Entry k is ((7·k) mod 16)·16 + 8. The pointer advances by one on every run cycle and wraps from 15 to 0. After each run cycle, rnd_o shows the entry used in that cycle, so consecutive run cycles without a load show different words.
- R4: After each run cycle, bit_o is 1 exactly when the probability used is strictly greater than the random word. Equality gives 0, and a probability of 0 never gives a 1.
- R5: A load restarts the pointer at the SEED parameter. When load_i and run_i are high in the same cycle, that cycle's bit already uses the new probability and table entry SEED. The next run cycle then uses entry SEED+1.
- R6: In a cycle with run_i low, bit_o becomes 0 and both the pointer and rnd_o hold. A load without run updates prob_o only.
- R7: Synchronous active-high reset sets prob_o to 128, rnd_o to 0 and bit_o to 0, and places the pointer at SEED.
- R8: Over 16 consecutive run cycles without a load, bit_o is 1 in exactly as many cycles as there are table entries below the probability.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Captures sample_i and restarts the random pointer |
| run_i | input | 1 | Produces one stream bit this cycle |
| sample_i | input | IN_W | Signed received soft sample |
| bit_o | output | 1 | Registered stochastic stream bit |
| prob_o | output | PROB_W | Encoded probability word |
| rnd_o | output | PROB_W | Random word used in the last run cycle |

## Verification
The two functions that can coincide are capturing a new symbol and producing a stream bit. When both happen in the same edge, the bit must already use the new probability and the seed entry of the table, not the old values. The bench provokes this by asserting the strobe and the enable together at the start of every vector. It judges prob_o, rnd_o and bit_o after that edge against the seed word and the vector's expected probability. It then confirms that the next cycle moves on to entry SEED+1. Separate directed cases apply a load with the enable low, and resume the enable after idle cycles, to separate the two paths.

// File: rtl/cse_pkg.sv
package cse_pkg;
  // Random table word k: a stride permutation of evenly spaced levels,
  // each sitting in the middle of its bin.
  function automatic int rnd_word(input int k, input int depth,
                                  input int mul, input int prob_w);
    int step;
    step = (1 << prob_w) / depth;
    return ((k * mul) % depth) * step + step / 2;
  endfunction
endpackage

// File: rtl/cse_scaler.sv
module cse_scaler #(
  parameter int IN_W      = 8,
  parameter int IDX_W     = 6,
  parameter int SCALE_NUM = 3,
  parameter int SCALE_SH  = 1
) (
  input  logic [IN_W-1:0]  sample_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int PW = IN_W + 16;
  localparam logic signed [PW-1:0] HI = PW'(2 ** (IDX_W - 1) - 1);
  localparam logic signed [PW-1:0] LO = PW'(-(2 ** (IDX_W - 1)));

  logic signed [PW-1:0]    ext, prod, shf, clip;
  logic signed [IDX_W-1:0] s_n;

  always_comb begin
    ext  = {{(PW-IN_W){sample_i[IN_W-1]}}, sample_i};
    prod = ext * $signed(PW'(SCALE_NUM));
    shf  = prod >>> SCALE_SH;
    if (shf > HI)      clip = HI;
    else if (shf < LO) clip = LO;
    else               clip = shf;
    s_n   = IDX_W'(clip);
    // offset-binary index: most negative value maps to entry 0
    idx_o = {~s_n[IDX_W-1], s_n[IDX_W-2:0]};
  end
endmodule

// File: rtl/cse_prob_map.sv
module cse_prob_map #(
  parameter int IDX_W  = 6,
  parameter int PROB_W = 8
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PROB_W-1:0] prob_o
);
  localparam int DEPTH = 2 ** IDX_W;
  localparam int SH    = PROB_W - IDX_W;

  logic [PROB_W-1:0] tab [DEPTH];

  // Linear saturating ramp standing in for the logistic curve
  for (genvar k = 0; k < DEPTH; k++) begin : g_ramp
    assign tab[k] = PROB_W'(k << SH);
  end

  assign prob_o = tab[idx_i];
endmodule

// File: rtl/cse_rnd_src.sv
module cse_rnd_src #(
  parameter int PROB_W    = 8,
  parameter int RND_DEPTH = 16,
  parameter int RND_MUL   = 7,
  parameter int SEED      = 0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic              run_i,
  output logic [PROB_W-1:0] word_o
);
  localparam int PTR_W = $clog2(RND_DEPTH);
  localparam logic [PTR_W-1:0] SEED_P = PTR_W'(SEED);

  logic [PROB_W-1:0] tab [RND_DEPTH];
  logic [PTR_W-1:0]  ptr_q, sel;

  for (genvar k = 0; k < RND_DEPTH; k++) begin : g_tab
    assign tab[k] = PROB_W'(cse_pkg::rnd_word(k, RND_DEPTH, RND_MUL, PROB_W));
  end

  assign sel    = load_i ? SEED_P : ptr_q;
  assign word_o = tab[sel];

  always_ff @(posedge clk_i) begin
    if (rst_i)       ptr_q <= SEED_P;
    else if (run_i)  ptr_q <= sel + 1'b1;
    else if (load_i) ptr_q <= SEED_P;
  end
endmodule

// File: rtl/chan_stoch_enc.sv
module chan_stoch_enc #(
  parameter int IN_W      = 8,
  parameter int PROB_W    = 8,
  parameter int IDX_W     = 6,
  parameter int SCALE_NUM = 3,
  parameter int SCALE_SH  = 1,
  parameter int RND_DEPTH = 16,
  parameter int RND_MUL   = 7,
  parameter int SEED      = 0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [IN_W-1:0]   sample_i,
  output logic              bit_o,
  output logic [PROB_W-1:0] prob_o,
  output logic [PROB_W-1:0] rnd_o
);
  localparam logic [PROB_W-1:0] MID = PROB_W'(2 ** (PROB_W - 1));

  logic [IDX_W-1:0]  idx;
  logic [PROB_W-1:0] map_prob, prob_q, x_nx, rword, rnd_q;
  logic              bit_q;

  cse_scaler #(.IN_W(IN_W), .IDX_W(IDX_W), .SCALE_NUM(SCALE_NUM),
               .SCALE_SH(SCALE_SH)) scaler_i (
    .sample_i(sample_i), .idx_o(idx));

  cse_prob_map #(.IDX_W(IDX_W), .PROB_W(PROB_W)) map_i (
    .idx_i(idx), .prob_o(map_prob));

  cse_rnd_src #(.PROB_W(PROB_W), .RND_DEPTH(RND_DEPTH), .RND_MUL(RND_MUL),
                .SEED(SEED)) rnd_i (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(load_i), .run_i(run_i),
    .word_o(rword));

  // a load in the same cycle feeds the fresh probability straight to the compare
  assign x_nx = load_i ? map_prob : prob_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prob_q <= MID;
      rnd_q  <= '0;
      bit_q  <= 1'b0;
    end else begin
      if (load_i) prob_q <= map_prob;
      if (run_i) begin
        bit_q <= (x_nx > rword);
        rnd_q <= rword;
      end else begin
        bit_q <= 1'b0;
      end
    end
  end

  assign bit_o  = bit_q;
  assign prob_o = prob_q;
  assign rnd_o  = rnd_q;
endmodule

// File: rtl/chan_stoch_enc_chk.sv
module cse_chk #(
  parameter int PROB_W    = 8,
  parameter int RND_DEPTH = 16,
  parameter int RND_MUL   = 7,
  parameter int SEED      = 0
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              load_i,
  input logic              run_i,
  input logic              bit_o,
  input logic [PROB_W-1:0] prob_o,
  input logic [PROB_W-1:0] rnd_o
);
  localparam logic [PROB_W-1:0] SEED_WORD =
    PROB_W'(cse_pkg::rnd_word(SEED, RND_DEPTH, RND_MUL, PROB_W));

  p_stream_match_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(run_i) && !$past(rst_i)) |-> (bit_o == (prob_o > rnd_o)));

  p_zero_never_one_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (prob_o == '0) |-> !bit_o);

  p_fresh_word_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && !load_i && $past(run_i) && !$past(rst_i)) |=> (rnd_o != $past(rnd_o)));

  p_seed_restart_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && run_i) |=> (rnd_o == SEED_WORD));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run_i && !load_i) |=> (!bit_o && $stable(rnd_o) && $stable(prob_o)));

  p_load_only_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && !run_i) |=> (!bit_o && $stable(rnd_o)));
endmodule

bind chan_stoch_enc cse_chk #(
  .PROB_W(PROB_W), .RND_DEPTH(RND_DEPTH), .RND_MUL(RND_MUL), .SEED(SEED)
) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .load_i(load_i), .run_i(run_i),
  .bit_o(bit_o), .prob_o(prob_o), .rnd_o(rnd_o)
);

// File: tb/chan_stoch_enc_tb_top.sv
module chan_stoch_enc_tb_top;
  localparam int SEED = 3;
  localparam int NV   = 11;
  // sample and expected probability, from R1/R2 by hand
  localparam int VEC_Y [NV] = '{0, 1, -1, 20, 21, 127, -21, -128, -20, 10, -7};
  localparam int VEC_X [NV] = '{128, 132, 120, 248, 252, 252, 0, 0, 8, 188, 84};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic       run = 1'b0;
  logic [7:0] sample = '0;
  logic       bit_w;
  logic [7:0] prob_w, rnd_w;
  int total = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  chan_stoch_enc #(.SEED(SEED)) dut_i (
    .clk_i(clk), .rst_i(rst), .load_i(load), .run_i(run), .sample_i(sample),
    .bit_o(bit_w), .prob_o(prob_w), .rnd_o(rnd_w));

  function automatic int exp_r(input int k);
    return (((k % 16) * 7) % 16) * 16 + 8;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic l, input logic r, input int y);
    load = l; run = r; sample = 8'(y);
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; total++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int k;
    int ones;
    int below;
    tick(0, 0, 0); tick(0, 0, 0);
    rst = 1'b0;
    #1;
    chk("R7 reset prob", prob_w, 128);
    chk("R7 reset rnd", rnd_w, 0);
    chk("R7 reset bit", bit_w, 0);
    tick(0, 1, 0);
    chk("R7 pointer at seed after reset", rnd_w, exp_r(SEED));
    chk("R4 reset prob compare", bit_w, (128 > exp_r(SEED)) ? 1 : 0);

    for (int v = 0; v < NV; v++) begin
      tick(1, 1, VEC_Y[v]);
      chk("R2 probability after load", prob_w, VEC_X[v]);
      chk("R5 load and run use seed entry", rnd_w, exp_r(SEED));
      chk("R5 same-cycle bit uses new probability", bit_w,
          (VEC_X[v] > exp_r(SEED)) ? 1 : 0);
      ones = 0; below = 0;
      for (int c = 1; c <= 16; c++) begin
        k = SEED + c;
        tick(0, 1, 0);
        chk("R3 table walk", rnd_w, exp_r(k));
        chk("R4 compare bit", bit_w, (VEC_X[v] > exp_r(k)) ? 1 : 0);
        ones += int'(bit_w);
        if (exp_r(k) < VEC_X[v]) below++;
      end
      chk("R8 ones count over full table", ones, below);
      chk("R1 saturated probability held", prob_w, VEC_X[v]);
    end

    // idle hold: pointer and words frozen while run is low
    tick(1, 1, 10);
    tick(0, 1, 0);
    chk("R6 pre-idle word", rnd_w, exp_r(SEED + 1));
    tick(0, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    chk("R6 idle bit low", bit_w, 0);
    chk("R6 idle rnd held", rnd_w, exp_r(SEED + 1));
    chk("R6 idle prob held", prob_w, 188);
    tick(0, 1, 0);
    chk("R6 pointer held across idle", rnd_w, exp_r(SEED + 2));

    // load without run: probability only
    tick(1, 0, -20);
    chk("R6 load-only prob", prob_w, 8);
    chk("R6 load-only bit", bit_w, 0);
    chk("R6 load-only rnd held", rnd_w, exp_r(SEED + 2));
    tick(0, 1, 0);
    chk("R5 restart at seed after load-only", rnd_w, exp_r(SEED));
    tick(0, 1, 0);
    chk("R5 next entry after seed", rnd_w, exp_r(SEED + 1));

    // reset mid-stream
    rst = 1'b1;
    tick(0, 1, 0);
    rst = 1'b0;
    #1;
    chk("R7 reset mid-run prob", prob_w, 128);
    chk("R7 reset mid-run rnd", rnd_w, 0);
    chk("R7 reset mid-run bit", bit_w, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule